// File: doc/BRIEF.md
# ECC Chunk Status Page Aggregator

After a page read, an error-correction engine leaves one status byte for each codeword chunk. This block takes those bytes one at a time and reduces them to page-level figures. It produces a page failure flag, the largest number of bit flips corrected in any single chunk, the sum of all corrected bits, and the number of chunks that could not be corrected. The parity decoding itself happens elsewhere. This block only interprets the per-chunk verdict codes.

Each byte in the stream is qualified by `st_valid`. A page opens with a `frame_start` pulse, and `st_last` marks its final byte. When the final byte is accepted, the figures are complete. `result_valid` then pulses one cycle later, and the figures stay on the outputs until the next `frame_start`. Software policy is simple: a page with any failed chunk is a read failure; otherwise the largest per-chunk correction count is compared against a wear threshold.

Top module: `ecc_page_verdict`

## Requirements
- R1: After synchronous reset, all result outputs read zero, `result_valid` is low, and no page is open.
- R2: A status code of 0x00 denotes a clean chunk and leaves every result output unchanged.
- R3: The erased-chunk code 0xFF counts neither as a correction nor as a failure; every result output stays unchanged.
- R4: The uncorrectable code 0xFE, and every code from 0x29 (41) to 0xFD, marks the chunk as failed. Each such chunk raises `page_fail` and adds one to `fail_count`.
- R5: A code from 1 to 40 is a corrected-bit count. It is added to `total_flips`, and `max_flips` becomes the larger of its old value and the code.
- R6: `frame_start` clears all four result outputs. A byte accepted in the same cycle as `frame_start` is counted as the first byte of the new page.
- R7: `result_valid` is high in exactly the cycle after a byte with `st_last` is accepted, and low otherwise.
- R8: Between an accepted last byte and the next `frame_start`, valid bytes are ignored and all results hold. The same applies after reset before any `frame_start`.
- R9: `fail_count` and `total_flips` saturate at their all-ones value instead of wrapping.
- R10: On a mixed page, `page_fail` is high exactly when at least one chunk failed. `max_flips` and `total_flips` cover only the corrected chunks, whatever the failed and erased chunks in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Opens a new page and clears the results |
| st_valid | input | 1 | Status byte qualifier |
| st_last | input | 1 | Marks the final status byte of the page |
| st_code | input | CODE_W | Per-chunk status code |
| page_fail | output | 1 | At least one chunk of the page was uncorrectable |
| max_flips | output | CODE_W | Largest corrected-bit count of any single chunk |
| total_flips | output | TOT_W | Sum of corrected bits, saturating |
| fail_count | output | CNT_W | Number of failed chunks, saturating |
| result_valid | output | 1 | One-cycle pulse after the last byte is accepted |

## Verification
The bench builds the block with `MAX_CHUNKS` = 4, so `fail_count` is 3 bits wide and `total_flips` is 8 bits wide. With these widths, both saturation limits can be reached with a nine-byte page. The 8-bit code width lets the bench sweep all 256 status codes as single-chunk pages, covering every code class and both edges of the correction range. Multi-chunk pages mix clean, erased, failed and corrected codes. Further sequences cover a byte arriving together with `frame_start`, back-to-back single-byte pages, and bytes sent outside an open page.

// File: rtl/ecc_verdict_pkg.sv
// Shared types for the per-chunk ECC status aggregator.
// Assumes nothing beyond a standard SystemVerilog compile of this package first.
package ecc_verdict_pkg;

    // Interpretation of one chunk status code
    typedef enum logic [1:0] {
        CHK_CLEAN  = 2'd0,
        CHK_ERASED = 2'd1,
        CHK_FIXED  = 2'd2,
        CHK_FAILED = 2'd3
    } chunk_kind_e;

endpackage

// File: rtl/ecc_code_classifier.sv
// Combinational decode of one chunk status code into a chunk kind and the
// number of flips it contributes to the correction figures.
// Assumes the erased and uncorrectable codes lie above MAX_CORR and are
// distinct from zero; the erased code is checked first.
module ecc_code_classifier
    import ecc_verdict_pkg::*;
#(
    parameter int                CODE_W      = 8,
    parameter int                MAX_CORR    = 40,
    parameter logic [CODE_W-1:0] ERASED_CODE = '1,
    parameter logic [CODE_W-1:0] UNCORR_CODE = {{(CODE_W-1){1'b1}}, 1'b0}
) (
    input  logic [CODE_W-1:0] code,
    output chunk_kind_e       kind,
    output logic [CODE_W-1:0] flips
);

    localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(MAX_CORR);

    // Pick the chunk kind in priority order: erased, clean, failed, corrected
    always_comb begin
        if (code == ERASED_CODE) begin
            kind = CHK_ERASED;
        end else if (code == '0) begin
            kind = CHK_CLEAN;
        end else if ((code == UNCORR_CODE) || (code > MAX_CODE)) begin
            kind = CHK_FAILED;
        end else begin
            kind = CHK_FIXED;
        end
    end

    // Only corrected chunks carry a flip count into the figures
    always_comb begin
        flips = (kind == CHK_FIXED) ? code : '0;
    end

endmodule

// File: rtl/ecc_frame_ctrl.sv
// Page framing: tracks whether a page is open, decides which status bytes
// are accepted, and pulses result_valid one cycle after the last one.
// Assumes frame_start may coincide with a valid byte, which then belongs
// to the new page.
module ecc_frame_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic st_valid,
    input  logic st_last,
    output logic accept,
    output logic clear,
    output logic result_valid
);

    logic page_open;

    // A byte counts when a page is open or is being opened this cycle
    always_comb begin
        accept = st_valid && (page_open || frame_start);
        clear  = frame_start;
    end

    // Open on start, close once the last byte has been taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_open <= 1'b0;
        end else if (frame_start) begin
            page_open <= !(st_valid && st_last);
        end else if (accept && st_last) begin
            page_open <= 1'b0;
        end
    end

    // Announce completed results in the cycle after the last byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_valid <= 1'b0;
        end else begin
            result_valid <= accept && st_last;
        end
    end

    // R7: a last byte arriving with start always produces a result pulse
    p_start_last_reports_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && st_valid && st_last) |=> result_valid);

    // R7: without any valid byte there is no result pulse next cycle
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_valid) |=> !result_valid);

endmodule

// File: rtl/ecc_verdict_accum.sv
// Page-level accumulation of failure flag, worst chunk, corrected total and
// failed-chunk count. Counts saturate at all-ones.
// Assumes clear and accept arrive from the framing logic; a byte accepted
// together with clear is applied on top of the cleared state.
module ecc_verdict_accum
    import ecc_verdict_pkg::*;
#(
    parameter int CODE_W   = 8,
    parameter int MAX_CORR = 40,
    parameter int TOT_W    = 10,
    parameter int CNT_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              accept,
    input  chunk_kind_e       kind,
    input  logic [CODE_W-1:0] flips,
    output logic              page_fail,
    output logic [CODE_W-1:0] max_flips,
    output logic [TOT_W-1:0]  total_flips,
    output logic [CNT_W-1:0]  fail_count
);

    localparam logic [TOT_W-1:0] TOT_SAT = '1;
    localparam logic [CNT_W-1:0] CNT_SAT = '1;

    logic              base_fail;
    logic [CODE_W-1:0] base_max;
    logic [TOT_W-1:0]  base_tot;
    logic [CNT_W-1:0]  base_cnt;
    logic [TOT_W:0]    tot_sum;
    logic              nxt_fail;
    logic [CODE_W-1:0] nxt_max;
    logic [TOT_W-1:0]  nxt_tot;
    logic [CNT_W-1:0]  nxt_cnt;

    // Starting point for this cycle: cleared on start, else current state
    always_comb begin
        base_fail = clear ? 1'b0 : page_fail;
        base_max  = clear ? '0   : max_flips;
        base_tot  = clear ? '0   : total_flips;
        base_cnt  = clear ? '0   : fail_count;
    end

    // Widened sum so an overflow can be detected and clamped
    always_comb begin
        tot_sum = {1'b0, base_tot} + (TOT_W+1)'(flips);
    end

    // Fold the accepted byte into the figures
    always_comb begin
        nxt_fail = base_fail;
        nxt_max  = base_max;
        nxt_tot  = base_tot;
        nxt_cnt  = base_cnt;
        if (accept) begin
            if (kind == CHK_FAILED) begin
                nxt_fail = 1'b1;
                nxt_cnt  = (base_cnt == CNT_SAT) ? CNT_SAT : base_cnt + 1'b1;
            end else if (kind == CHK_FIXED) begin
                nxt_tot = tot_sum[TOT_W] ? TOT_SAT : tot_sum[TOT_W-1:0];
                nxt_max = (flips > base_max) ? flips : base_max;
            end
        end
    end

    // Result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_fail   <= 1'b0;
            max_flips   <= '0;
            total_flips <= '0;
            fail_count  <= '0;
        end else begin
            page_fail   <= nxt_fail;
            max_flips   <= nxt_max;
            total_flips <= nxt_tot;
            fail_count  <= nxt_cnt;
        end
    end

    // R4: the failure flag and the failed-chunk count agree
    p_flag_matches_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        page_fail == (fail_count != '0));

    // R4: each failed chunk below saturation adds exactly one
    p_fail_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !clear && kind == CHK_FAILED && fail_count != CNT_SAT)
        |=> fail_count == $past(fail_count) + 1'b1);

    // R5: the worst chunk never exceeds the correctable range
    p_max_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
        max_flips <= CODE_W'(MAX_CORR));

    // R6: a clear with no byte leaves an all-zero result
    p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !accept) |=> (!page_fail && max_flips == '0 &&
                                total_flips == '0 && fail_count == '0));

    // R8: with neither clear nor byte, every figure holds
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !accept) |=> $stable({page_fail, max_flips, total_flips, fail_count}));

    // R9: saturated counters stay saturated until cleared
    p_cnt_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_count == CNT_SAT && !clear) |=> fail_count == CNT_SAT);

endmodule

// File: rtl/ecc_page_verdict.sv
// Top of the per-chunk ECC status aggregator: classifies each status byte,
// frames the page and accumulates the page-level figures.
// Assumes one status byte per chunk, framed by frame_start and st_last.
module ecc_page_verdict
    import ecc_verdict_pkg::*;
#(
    parameter int                CODE_W      = 8,
    parameter int                MAX_CORR    = 40,
    parameter logic [CODE_W-1:0] ERASED_CODE = 8'hFF,
    parameter logic [CODE_W-1:0] UNCORR_CODE = 8'hFE,
    parameter int                MAX_CHUNKS  = 16,
    localparam int               CNT_W       = $clog2(MAX_CHUNKS + 1),
    localparam int               TOT_W       = $clog2(MAX_CHUNKS * MAX_CORR + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              st_valid,
    input  logic              st_last,
    input  logic [CODE_W-1:0] st_code,
    output logic              page_fail,
    output logic [CODE_W-1:0] max_flips,
    output logic [TOT_W-1:0]  total_flips,
    output logic [CNT_W-1:0]  fail_count,
    output logic              result_valid
);

    chunk_kind_e       kind;
    logic [CODE_W-1:0] flips;
    logic              accept;
    logic              clear;

    ecc_code_classifier #(
        .CODE_W      (CODE_W),
        .MAX_CORR    (MAX_CORR),
        .ERASED_CODE (ERASED_CODE),
        .UNCORR_CODE (UNCORR_CODE)
    ) u_class (
        .code  (st_code),
        .kind  (kind),
        .flips (flips)
    );

    ecc_frame_ctrl u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start  (frame_start),
        .st_valid     (st_valid),
        .st_last      (st_last),
        .accept       (accept),
        .clear        (clear),
        .result_valid (result_valid)
    );

    ecc_verdict_accum #(
        .CODE_W   (CODE_W),
        .MAX_CORR (MAX_CORR),
        .TOT_W    (TOT_W),
        .CNT_W    (CNT_W)
    ) u_accum (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear),
        .accept      (accept),
        .kind        (kind),
        .flips       (flips),
        .page_fail   (page_fail),
        .max_flips   (max_flips),
        .total_flips (total_flips),
        .fail_count  (fail_count)
    );

endmodule

// File: tb/ecc_page_verdict_test.sv
`timescale 1ns/1ps
module ecc_page_verdict_test;

    localparam int CW    = 8;
    localparam int MC    = 40;
    localparam int NCH   = 4;
    localparam int CNT_W = $clog2(NCH + 1);
    localparam int TOT_W = $clog2(NCH * MC + 1);
    localparam int CNT_MAX = (1 << CNT_W) - 1;
    localparam int TOT_MAX = (1 << TOT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             frame_start;
    logic             st_valid;
    logic             st_last;
    logic [CW-1:0]    st_code;
    logic             page_fail;
    logic [CW-1:0]    max_flips;
    logic [TOT_W-1:0] total_flips;
    logic [CNT_W-1:0] fail_count;
    logic             result_valid;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    int e_fail, e_max, e_tot, e_cnt;

    always #4 clk = ~clk;

    ecc_page_verdict #(.MAX_CHUNKS(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .st_valid(st_valid), .st_last(st_last), .st_code(st_code),
        .page_fail(page_fail), .max_flips(max_flips),
        .total_flips(total_flips), .fail_count(fail_count),
        .result_valid(result_valid)
    );

    // 0 clean, 1 erased, 2 corrected, 3 failed
    function automatic int kind_of(int c);
        if (c == 255) return 1;
        if (c == 0) return 0;
        if (c == 254 || c > MC) return 3;
        return 2;
    endfunction

    function automatic string tag_of(int c);
        case (kind_of(c))
            0: return "R2";
            1: return "R3";
            3: return "R4";
            default: return "R5";
        endcase
    endfunction

    function automatic int code_at(int idx);
        case (idx % 8)
            0: return 0;
            1: return 255;
            2: return 254;
            3: return 1;
            4: return 40;
            5: return 41;
            6: return 17;
            default: return 200;
        endcase
    endfunction

    task automatic model_clear();
        e_fail = 0; e_max = 0; e_tot = 0; e_cnt = 0;
    endtask

    task automatic model_add(int c);
        int k;
        k = kind_of(c);
        if (k == 3) begin
            e_fail = 1;
            if (e_cnt < CNT_MAX) e_cnt++;
        end else if (k == 2) begin
            e_tot = (e_tot + c > TOT_MAX) ? TOT_MAX : e_tot + c;
            if (c > e_max) e_max = c;
        end
    endtask

    task automatic check(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req, int rv);
        check(req, "result_valid", int'(result_valid), rv);
        check(req, "page_fail", int'(page_fail), e_fail);
        check(req, "max_flips", int'(max_flips), e_max);
        check(req, "total_flips", int'(total_flips), e_tot);
        check(req, "fail_count", int'(fail_count), e_cnt);
    endtask

    task automatic cyc(bit s, bit v, bit l, int c);
        @(negedge clk);
        frame_start = s;
        st_valid    = v;
        st_last     = l;
        st_code     = CW'(c);
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
        end
    end

    initial begin
        rst_n = 1'b0;
        frame_start = 0; st_valid = 0; st_last = 0; st_code = '0;
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check_all("R1", 0);

        // R8: bytes before any start are ignored
        cyc(0, 1, 1, 254);
        idle();
        check_all("R8", 0);

        // R2 R3 R4 R5: every code as a one-chunk page
        for (int c = 0; c < 256; c++) begin
            cyc(1, 0, 0, 0);
            model_clear();
            cyc(0, 1, 1, c);
            model_add(c);
            idle();
            check_all(tag_of(c), 1);
            idle();
            check_all("R8", 0);
        end

        // R10: mixed multi-chunk pages
        for (int p = 0; p < 64; p++) begin
            int len;
            len = 1 + (p % NCH);
            cyc(1, 0, 0, 0);
            model_clear();
            for (int i = 0; i < len; i++) begin
                int c;
                c = code_at(p * 3 + i * 5);
                cyc(0, 1, (i == len - 1), c);
                model_add(c);
            end
            idle();
            check_all("R10", 1);
        end

        // R6: byte in the start cycle counts as first byte
        model_clear();
        cyc(1, 1, 0, 5);
        model_add(5);
        cyc(0, 1, 1, 7);
        model_add(7);
        idle();
        check_all("R6", 1);

        // R8: bytes after the last are ignored
        cyc(0, 1, 0, 254);
        cyc(0, 1, 1, 30);
        idle();
        check_all("R8", 0);

        // R6: start alone clears
        cyc(1, 0, 0, 0);
        model_clear();
        idle();
        check_all("R6", 0);

        // R9: failed-chunk count saturates
        cyc(1, 0, 0, 0);
        model_clear();
        for (int i = 0; i < 9; i++) begin
            cyc(0, 1, (i == 8), 254);
            model_add(254);
        end
        idle();
        check_all("R9", 1);

        // R9: corrected total saturates
        cyc(1, 0, 0, 0);
        model_clear();
        for (int i = 0; i < 7; i++) begin
            cyc(0, 1, (i == 6), 40);
            model_add(40);
        end
        idle();
        check_all("R9", 1);

        // R7: back-to-back single-byte pages
        model_clear();
        model_add(3);
        cyc(1, 1, 1, 3);
        cyc(1, 1, 1, 9);
        check_all("R7", 1);
        model_clear();
        model_add(9);
        idle();
        check_all("R7", 1);
        idle();
        check_all("R7", 0);

        done = 1;
        summary();
    end

endmodule